// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts hardware activity for profiling. A free-running cycle counter and two event counters sit behind one packed control word. Each event counter picks one line out of a 256-wide vector of single-cycle event pulses through an 8-bit selector code. Each counter has its own overflow flag, and an interrupt enable decides whether that flag raises the interrupt line.

Software turns the monitor on with one global enable bit. It clears counters with self-clearing reset bits in the same word. It can preload any counter through that counter's own register address, so that an overflow interrupt fires after a chosen number of events. A divided mode slows the cycle counter so that it covers long intervals.

All register accesses are single-cycle. Reads are combinational from the address. Writes take effect at the clock edge on which `reg_wr` is sampled high.

Top module: `perf_event_monitor`

## Requirements
- R1: After reset every counter reads 0, the control word reads 0 and `irq` is low.
- R2: While control bit 0 (global enable) is 0, no counter changes except through a direct register write.
- R3: With the enable set and control bit 3 clear, the cycle counter (address 1) gains exactly one per clock edge.
- R4: With control bit 3 set, the cycle counter gains one per 64 enabled clock edges. The divider restarts from zero when the cycle counter is reset.
- R5: Event counter 0 (address 2) counts clock edges where the enable is set and `evt_in[sel0]` is high. Event counter 1 (address 3) does the same with `evt_in[sel1]`. sel0 is control bits 19:12 and sel1 is control bits 27:20. No other event line affects either counter.
- R6: A selector code of 0xFF stops that event counter, whatever its inputs do.
- R7: Writing 1 to control bit 1 zeroes both event counters, and writing 1 to control bit 2 zeroes the cycle counter. Both bits read back as 0. A reset beats an increment in the same cycle.
- R8: A counter that wraps from all ones to 0 sets its own flag. The flags are control bit 8 (event 0), bit 9 (event 1) and bit 10 (cycle). Flags are sticky: a new overflow never clears a flag that is already set.
- R9: A control write with 1 in a flag bit clears that flag. A 0 there leaves it unchanged.
- R10: `irq` is high exactly while some flag is set together with its enable. The enables are control bit 4 (event 0), bit 5 (event 1) and bit 6 (cycle).
- R11: Control bits 7, 11 and 31:28 ignore writes and read as 0.
- R12: Each counter can be written and read back directly at its address (1 cycle, 2 event 0, 3 event 1). A written value is visible on the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_in | input | 256 | Single-cycle event pulses |
| irq | output | 1 | Active-high overflow interrupt |

## Verification
Each counter register holds its new value from the edge that samples a write, a reset bit or an event. The bench therefore drives on falling edges and reads on the following falling edge, so a step of N events appears after exactly N rising edges. The interrupt is decoded straight from the flag registers, so it is checked on the same falling edge as the flag it follows. In divided mode the first cycle-counter step is due on the 64th edge after the reset write, and the bench checks the values on both sides of that edge.

// File: rtl/pem_pkg.sv
package pem_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned EN_B     = 0;
   localparam int unsigned EVCLR_B  = 1;
   localparam int unsigned CYCLR_B  = 2;
   localparam int unsigned DIV_B    = 3;
   localparam int unsigned IE_LO    = 4;
   localparam int unsigned FLG_LO   = 8;
   localparam int unsigned SEL0_LO  = 12;
   localparam int unsigned SEL1_LO  = 20;
   localparam int unsigned NUM_SLOT = 3;   // slot 0 event0, slot 1 event1, slot 2 cycle

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_CYC  = 2'd1,
      A_EV0  = 2'd2,
      A_EV1  = 2'd3
   } pem_addr_e;
endpackage

// File: rtl/pem_counter.sv
module pem_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   localparam logic [W-1:0] ALL1 = '1;

   assign wrap = inc && !clr && !load && (cnt == ALL1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (load) cnt <= load_val;
      else if (inc)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pem_prescale.sv
module pem_prescale #(
   parameter int unsigned LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   localparam logic [LOG2-1:0] TOP = '1;
   logic [LOG2-1:0] pre;

   assign tick = run && !clr && (pre == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre <= '0;
      else if (clr) pre <= '0;
      else if (run) pre <= pre + 1'b1;
   end
endmodule

// File: rtl/pem_evsel.sv
module pem_evsel #(
   parameter int unsigned SEL_W = 8,
   localparam int unsigned N    = 1 << SEL_W
) (
   input  logic [N-1:0]     evt,
   input  logic [SEL_W-1:0] sel,
   output logic             hit
);
   localparam logic [SEL_W-1:0] OFF = '1;
   assign hit = (sel != OFF) && evt[sel];
endmodule

// File: rtl/perf_event_monitor.sv
module perf_event_monitor
   import pem_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned SEL_W    = 8,
   parameter int unsigned DIV_LOG2 = 6,
   localparam int unsigned NEVT    = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NEVT-1:0]   evt_in,
   output logic              irq
);
   if (SEL_W != 8) begin : g_bad_sel
      $error("selector fields are fixed at 8 bits in the control word");
   end
   if (CNT_W == 0 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("counter width must be 1..32");
   end

   logic                en_q, div_q;
   logic [2:0]          ie_q, flg_q, wrap;
   logic [SEL_W-1:0]    sel_q [2];
   logic [CNT_W-1:0]    ev_cnt [2];
   logic [CNT_W-1:0]    cyc_cnt;
   logic [1:0]          ev_hit;
   logic                tick;
   logic                wdata_unused;

   wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   wire clr_ev  = wr_ctrl && reg_wdata[EVCLR_B];
   wire clr_cy  = wr_ctrl && reg_wdata[CYCLR_B];

   assign wdata_unused = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

   // control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         div_q    <= 1'b0;
         ie_q     <= '0;
         sel_q[0] <= '0;
         sel_q[1] <= '0;
      end else if (wr_ctrl) begin
         en_q     <= reg_wdata[EN_B];
         div_q    <= reg_wdata[DIV_B];
         ie_q     <= reg_wdata[IE_LO +: 3];
         sel_q[0] <= reg_wdata[SEL0_LO +: SEL_W];
         sel_q[1] <= reg_wdata[SEL1_LO +: SEL_W];
      end
   end

   // sticky flags, write-one-to-clear, a new wrap wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= (flg_q & ~(wr_ctrl ? reg_wdata[FLG_LO +: 3] : 3'b000)) | wrap;
   end

   // cycle tick source: every cycle, or divided
   if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      pem_prescale #(.LOG2(DIV_LOG2)) u_pre (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (clr_cy || !div_q),
         .run  (en_q && div_q),
         .tick (tick)
      );
   end

   pem_counter #(.W(CNT_W)) u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_cy),
      .load    (reg_wr && (reg_addr == A_CYC)),
      .load_val(reg_wdata[CNT_W-1:0]),
      .inc     (en_q && (div_q ? tick : 1'b1)),
      .cnt     (cyc_cnt),
      .wrap    (wrap[2])
   );

   for (genvar i = 0; i < 2; i++) begin : g_ev
      pem_evsel #(.SEL_W(SEL_W)) u_sel (
         .evt(evt_in),
         .sel(sel_q[i]),
         .hit(ev_hit[i])
      );
      pem_counter #(.W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr_ev),
         .load    (reg_wr && (reg_addr == ((i == 0) ? A_EV0 : A_EV1))),
         .load_val(reg_wdata[CNT_W-1:0]),
         .inc     (en_q && ev_hit[i]),
         .cnt     (ev_cnt[i]),
         .wrap    (wrap[i])
      );
   end

   assign irq = |(flg_q & ie_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[EN_B]              = en_q;
            reg_rdata[DIV_B]             = div_q;
            reg_rdata[IE_LO +: 3]        = ie_q;
            reg_rdata[FLG_LO +: 3]       = flg_q;
            reg_rdata[SEL0_LO +: SEL_W]  = sel_q[0];
            reg_rdata[SEL1_LO +: SEL_W]  = sel_q[1];
         end
         A_CYC:   reg_rdata = DATA_W'(cyc_cnt);
         A_EV0:   reg_rdata = DATA_W'(ev_cnt[0]);
         default: reg_rdata = DATA_W'(ev_cnt[1]);
      endcase
   end
endmodule

// File: rtl/pem_checker.sv
module pem_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             irq,
   input logic             en,
   input logic             div,
   input logic [2:0]       ie,
   input logic [2:0]       flg,
   input logic [CNT_W-1:0] cyc,
   input logic [CNT_W-1:0] ev0
);
   localparam logic [CNT_W-1:0] ALL1 = '1;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reg_wr) |=> (cyc == $past(cyc)) && (ev0 == $past(ev0)));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !div && !reg_wr && cyc != ALL1) |=> cyc == CNT_W'($past(cyc) + 1'b1));

   p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && reg_wdata[2]) |=> cyc == '0);

   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !div && !reg_wr && cyc == ALL1) |=> flg[2]);

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flg[0] && !(reg_wr && reg_addr == 2'd0 && reg_wdata[8])) |=> flg[0]);

   p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && reg_wdata[10] && !(en && cyc == ALL1)) |=> !flg[2]);

   p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flg & ie)) |-> irq);

   p_rsv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> (reg_rdata[31:28] == 4'd0 && !reg_rdata[11]
                              && !reg_rdata[7] && reg_rdata[2:1] == 2'd0));
endmodule

bind perf_event_monitor pem_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .irq      (irq),
   .en       (en_q),
   .div      (div_q),
   .ie       (ie_q),
   .flg      (flg_q),
   .cyc      (cyc_cnt),
   .ev0      (ev_cnt[0])
);

// File: tb/perf_event_monitor_test.sv
module perf_event_monitor_test;
   localparam int CLK_P = 10;

   logic         clk = 0;
   logic         rst_n = 0;
   logic         reg_wr = 0;
   logic [1:0]   reg_addr = 0;
   logic [31:0]  reg_wdata = 0;
   logic [31:0]  reg_rdata;
   logic [255:0] evt_in = '0;
   logic         irq;

   int total = 0, fails = 0;
   bit done = 0;

   perf_event_monitor uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [31:0] mk_ctrl(input logic en, input logic dv,
      input logic [2:0] ie, input logic [2:0] fl, input logic [7:0] s0, input logic [7:0] s1);
      return {4'd0, s1, s0, 1'b0, fl, 1'b0, ie, dv, 2'b00, en};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic pulse(input int idx);
      evt_in = '0; evt_in[idx] = 1'b1;
      @(negedge clk); evt_in = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, b, c, d, sh;
      int m0, m1;
      void'($urandom(32'd4242));
      #(CLK_P*3) rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd(0, a); chk("R1 ctrl", a, 0);
      rd(1, a); chk("R1 cyc", a, 0);
      rd(2, a); chk("R1 ev0", a, 0);
      rd(3, a); chk("R1 ev1", a, 0);
      chk("R1 irq", {31'd0, irq}, 0);

      // R2 disabled: events and clock do not count
      for (int i = 0; i < 10; i++) pulse(0);
      rd(1, a); chk("R2 cyc idle", a, 0);
      rd(2, a); chk("R2 ev0 idle", a, 0);

      // R3 cycle counting
      sh = mk_ctrl(1, 0, 0, 0, 8'd5, 8'd9);
      wr(0, sh);
      rd(1, a); repeat (20) @(negedge clk); rd(1, b);
      chk("R3 cyc step", b - a, 20);

      // R5 directed event selection
      rd(2, a); rd(3, b);
      for (int i = 0; i < 7; i++) pulse(5);
      for (int i = 0; i < 3; i++) pulse(9);
      for (int i = 0; i < 6; i++) pulse(6);
      rd(2, c); rd(3, d);
      chk("R5 ev0 directed", c - a, 7);
      chk("R5 ev1 directed", d - b, 3);

      // R5 random selectors and random event vectors
      for (int r = 0; r < 3; r++) begin
         logic [7:0] s0, s1;
         s0 = 8'($urandom_range(0, 254));
         s1 = 8'($urandom_range(0, 254));
         wr(0, mk_ctrl(1, 0, 0, 0, s0, s1));
         rd(2, a); rd(3, b);
         m0 = 0; m1 = 0;
         for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < 8; k++) evt_in[k*32 +: 32] = $urandom;
            if (evt_in[s0]) m0++;
            if (evt_in[s1]) m1++;
            @(negedge clk);
         end
         evt_in = '0;
         rd(2, c); rd(3, d);
         chk("R5 ev0 random", c - a, m0);
         chk("R5 ev1 random", d - b, m1);
      end

      // R6 code 0xFF is unused
      sh = mk_ctrl(1, 0, 0, 0, 8'hFF, 8'd9);
      wr(0, sh);
      rd(2, a); rd(3, b);
      evt_in = '1; repeat (20) @(negedge clk);
      rd(2, c); rd(3, d);
      chk("R6 ev0 frozen", c - a, 0);
      chk("R6 ev1 counts", d - b, 20);

      // R7 resets beat increments (inputs all high during the write)
      wr(0, sh | 32'h6);
      rd(1, a); chk("R7 cyc cleared", a, 0);
      rd(2, a); chk("R7 ev0 cleared", a, 0);
      rd(3, a); chk("R7 ev1 cleared", a, 0);
      rd(0, a); chk("R7 self-clear", a, sh);
      evt_in = '0;

      // R4 divided mode
      sh = mk_ctrl(1, 1, 0, 0, 8'd5, 8'd9);
      wr(0, sh | 32'h4);
      rd(1, a); chk("R4 start", a, 0);
      repeat (63) @(negedge clk); rd(1, a); chk("R4 before tick", a, 0);
      @(negedge clk);             rd(1, a); chk("R4 first tick", a, 1);
      repeat (64) @(negedge clk); rd(1, a); chk("R4 second tick", a, 2);

      // R12 preload, R8 wrap, R10 interrupt
      sh = mk_ctrl(1, 0, 3'b100, 0, 8'd5, 8'd9);
      wr(0, sh);
      wr(1, 32'hFFFF_FFFD);
      rd(1, a); chk("R12 cyc preload", a, 32'hFFFF_FFFD);
      repeat (2) @(negedge clk);
      rd(1, a); chk("R8 cyc at top", a, 32'hFFFF_FFFF);
      rd(0, a); chk("R8 no flag yet", a, sh);
      chk("R10 irq low", {31'd0, irq}, 0);
      @(negedge clk);
      rd(1, a); chk("R8 cyc wrapped", a, 0);
      rd(0, a); chk("R8 cyc flag", a, mk_ctrl(1, 0, 3'b100, 3'b100, 8'd5, 8'd9));
      chk("R10 irq high", {31'd0, irq}, 1);

      // R8 independent sticky flags
      wr(2, 32'hFFFF_FFFF);
      rd(2, a); chk("R12 ev0 preload", a, 32'hFFFF_FFFF);
      pulse(5);
      rd(2, a); chk("R8 ev0 wrapped", a, 0);
      rd(0, a); chk("R8 both flags", a, mk_ctrl(1, 0, 3'b100, 3'b101, 8'd5, 8'd9));

      // R9 write-one-to-clear
      wr(0, sh | (32'd1 << 8));
      rd(0, a); chk("R9 clear ev0 only", a, mk_ctrl(1, 0, 3'b100, 3'b100, 8'd5, 8'd9));
      chk("R10 irq held", {31'd0, irq}, 1);
      wr(0, sh | (32'd1 << 10));
      rd(0, a); chk("R9 clear cyc", a, sh);
      chk("R10 irq dropped", {31'd0, irq}, 0);

      // R10 enable gating
      wr(2, 32'hFFFF_FFFF);
      pulse(5);
      rd(0, a); chk("R8 ev0 flag again", a, mk_ctrl(1, 0, 3'b100, 3'b001, 8'd5, 8'd9));
      chk("R10 masked", {31'd0, irq}, 0);
      sh = mk_ctrl(1, 0, 3'b101, 0, 8'd5, 8'd9);
      wr(0, sh);
      chk("R10 unmasked", {31'd0, irq}, 1);
      wr(0, sh | (32'd1 << 8));
      chk("R10 cleared", {31'd0, irq}, 0);

      // R11 reserved bits
      wr(0, sh | 32'hF000_0880);
      rd(0, a); chk("R11 reserved zero", a, sh);

      // R2 disable holds everything, R12 direct write while idle
      wr(0, 32'd0);
      wr(3, 32'h1234_5678);
      rd(3, a); chk("R12 ev1 write", a, 32'h1234_5678);
      rd(1, a); rd(2, b);
      for (int i = 0; i < 10; i++) pulse(5);
      repeat (20) @(negedge clk);
      rd(1, c); rd(2, d);
      chk("R2 cyc held", c, a);
      chk("R2 ev0 held", d, b);

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule